// File: doc/BRIEF.md
# Ternary Prefix Lookup Table

This block is a small associative table for routing lookups. Each entry holds a 64-bit word and a validity bit. A search compares a key against every valid entry in one clock and returns the lowest matching index, together with a hit flag. The search runs in one of two modes. Exact mode compares all 64 bits, which suits layer 2 MAC-style keys. Prefix mode takes a 32-bit IPv4 address and matches it against ternary-encoded entries. Both kinds of entry can share the same table.

In prefix mode, ternary position n (0 to 31) uses stored bits n and n+32:

| Stored value | Bit n | Bit n+32 |
|---|---|---|
| 0 | 0 | 1 |
| 1 | 1 | 0 |
| don't-care | 0 | 0 |

Longest-prefix routing works by writing longer prefixes at lower indices. The first hit is then the longest match.

Entries are written by index. The write index is presented on an external-RAM address port in the same cycle, so the associated data can be stored alongside. An entry is removed in one of two ways: by index, or by deleting the lowest valid entry that matches a key. Either way, the removed index is reported on a deletion address port. A full flag shows when every entry holds valid data.

Top module: `tcam_lookup`

## Requirements
- R1: When `wrEn` is high, `wrData` is stored at `wrIdx` and that entry becomes valid. In the same cycle, combinationally, `ramWe` is 1 and `ramAddr` equals `wrIdx`.
- R2: With `ternMode`=0, an entry matches only if all 64 stored bits equal `srchKey`.
- R3: With `ternMode`=1, only `srchKey[31:0]` is used. Key bit n=0 requires stored bit n to be 0. Key bit n=1 requires stored bit n+32 to be 0. A don't-care pair (both bits 0) therefore matches either key value.
- R4: When several valid entries match, `matchIdx` reports the lowest index.
- R5: `matchHit` and `matchIdx` are registered. They update on the clock edge that samples `srchEn` and hold their values until the next search. On a miss, `matchHit`=0 and `matchIdx`=0.
- R6: Reset clears every validity bit. An entry that is not valid never matches.
- R7: When `delIdxEn` is high, the entry at `delIdx` is invalidated. In the next cycle `delValid`=1 and `delAddr`=`delIdx`.
- R8: When `delMatchEn` is high, the lowest valid entry that matches `srchKey` under `ternMode` is invalidated, and in the next cycle `delValid`=1 and `delAddr` gives its index. If no entry matches, no entry changes and in the next cycle `delValid`=0 and `delAddr`=0.
- R9: `tableFull` is 1 exactly when every entry is valid. It reflects the validity state from the clock edge after a write or deletion.
- R10: If several commands are raised in one cycle, only one runs. The order is write, then delete by index, then delete by match, then search. A command that loses has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write an entry |
| wrIdx | input | 5 | Entry index for a write |
| wrData | input | 64 | Word to store |
| srchEn | input | 1 | Search request |
| delIdxEn | input | 1 | Invalidate the entry at `delIdx` |
| delIdx | input | 5 | Entry index for delete by index |
| delMatchEn | input | 1 | Invalidate the first entry matching `srchKey` |
| ternMode | input | 1 | 0 exact 64-bit compare, 1 prefix compare on `srchKey[31:0]` |
| srchKey | input | 64 | Search or delete-by-match key |
| matchHit | output | 1 | Registered hit flag of the last search |
| matchIdx | output | 5 | Registered lowest matching index, 0 on a miss |
| tableFull | output | 1 | All entries valid |
| ramWe | output | 1 | Write strobe for the external data RAM |
| ramAddr | output | 5 | External RAM address, equal to `wrIdx` |
| delValid | output | 1 | A deletion happened in the previous cycle |
| delAddr | output | 5 | Index of the deleted entry |

## Verification
Three kinds of result have different timing. `ramWe` and `ramAddr` are combinational, so the bench checks them during the write cycle itself, just after it drives the inputs and before the capturing edge. Search results, deletion reports and the full flag all change on the one edge that samples the command. The bench drives every command on a falling edge and reads the outputs on the following falling edge, exactly one register stage later. Hold behaviour and ignored commands are checked by issuing the competing request and then reading the same registered outputs.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  typedef enum logic {
    MODE_EXACT  = 1'b0,
    MODE_PREFIX = 1'b1
  } cmpMode_e;

  // one-cycle command strobes from control to datapath
  typedef struct packed {
    logic     doWrite;
    logic     doDelIdx;
    logic     doDelMatch;
    logic     doSearch;
    cmpMode_e mode;
  } camStrobe_t;

endpackage

// File: rtl/tcam_ctrl.sv
module tcam_ctrl
  import tcam_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic       delIdxEn,
  input  logic       delMatchEn,
  input  logic       srchEn,
  input  logic       ternMode,
  output camStrobe_t strobe
);

  // fixed priority: write, delete by index, delete by match, search
  always_comb begin
    strobe            = '0;
    strobe.mode       = ternMode ? MODE_PREFIX : MODE_EXACT;
    strobe.doWrite    = wrEn;
    strobe.doDelIdx   = delIdxEn && !wrEn;
    strobe.doDelMatch = delMatchEn && !wrEn && !delIdxEn;
    strobe.doSearch   = srchEn && !wrEn && !delIdxEn && !delMatchEn;
  end

  // R10
  single_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.doWrite, strobe.doDelIdx, strobe.doDelMatch, strobe.doSearch}));

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> strobe.doWrite && !strobe.doSearch);

endmodule

// File: rtl/tcam_datapath.sv
module tcam_datapath
  import tcam_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 64,
  localparam int IDXW = $clog2(DEPTH),
  localparam int HALF = WIDTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  camStrobe_t       strobe,
  input  logic [IDXW-1:0]  wrIdx,
  input  logic [WIDTH-1:0] wrData,
  input  logic [IDXW-1:0]  delIdx,
  input  logic [WIDTH-1:0] srchKey,
  output logic             matchHit,
  output logic [IDXW-1:0]  matchIdx,
  output logic             tableFull,
  output logic             delValid,
  output logic [IDXW-1:0]  delAddr
);

  logic [WIDTH-1:0] entry [DEPTH];
  logic [DEPTH-1:0] valid;
  logic [DEPTH-1:0] rowHit;
  logic [DEPTH-1:0] matchClear;
  logic [IDXW-1:0]  firstIdx;
  logic             anyHit;
  logic [HALF-1:0]  prefixKey;

  assign prefixKey = srchKey[HALF-1:0];

  // per-entry comparators, all evaluated in parallel
  for (genvar g = 0; g < DEPTH; g++) begin : gRow
    logic exactHit;
    logic prefixHit;
    assign exactHit  = (entry[g] == srchKey);
    assign prefixHit = ((entry[g][HALF-1:0] & ~prefixKey)
                      | (entry[g][WIDTH-1:HALF] & prefixKey)) == '0;
    assign rowHit[g] = valid[g] &&
                       ((strobe.mode == MODE_PREFIX) ? prefixHit : exactHit);
  end

  // lowest index wins
  always_comb begin
    firstIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (rowHit[i]) firstIdx = IDXW'(i);
    end
  end

  assign anyHit = |rowHit;

  always_comb begin
    matchClear = '0;
    if (strobe.doDelMatch && anyHit) matchClear[firstIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.doWrite) entry[wrIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
    end else if (strobe.doWrite) begin
      valid[wrIdx] <= 1'b1;
    end else if (strobe.doDelIdx) begin
      valid[delIdx] <= 1'b0;
    end else if (strobe.doDelMatch) begin
      valid <= valid & ~matchClear;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      matchHit <= 1'b0;
      matchIdx <= '0;
    end else if (strobe.doSearch) begin
      matchHit <= anyHit;
      matchIdx <= anyHit ? firstIdx : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delValid <= 1'b0;
      delAddr  <= '0;
    end else begin
      delValid <= strobe.doDelIdx || (strobe.doDelMatch && anyHit);
      if (strobe.doDelIdx)                   delAddr <= delIdx;
      else if (strobe.doDelMatch && anyHit)  delAddr <= firstIdx;
      else                                   delAddr <= '0;
    end
  end

  assign tableFull = &valid;

  // R5
  miss_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !matchHit |-> matchIdx == '0);

  // R1
  write_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doWrite |=> valid[$past(wrIdx)]);

  // R7
  del_idx_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doDelIdx |=> !valid[$past(delIdx)] && delValid);

  // R8
  del_match_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(matchClear));

  // R8
  del_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    delValid |-> $past(strobe.doDelIdx || strobe.doDelMatch));

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.doSearch |=> $stable(matchHit) && $stable(matchIdx));

endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup
  import tcam_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 64,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [IDXW-1:0]  wrIdx,
  input  logic [WIDTH-1:0] wrData,
  input  logic             srchEn,
  input  logic             delIdxEn,
  input  logic [IDXW-1:0]  delIdx,
  input  logic             delMatchEn,
  input  logic             ternMode,
  input  logic [WIDTH-1:0] srchKey,
  output logic             matchHit,
  output logic [IDXW-1:0]  matchIdx,
  output logic             tableFull,
  output logic             ramWe,
  output logic [IDXW-1:0]  ramAddr,
  output logic             delValid,
  output logic [IDXW-1:0]  delAddr
);

  camStrobe_t strobe;

  tcam_ctrl uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrEn       (wrEn),
    .delIdxEn   (delIdxEn),
    .delMatchEn (delMatchEn),
    .srchEn     (srchEn),
    .ternMode   (ternMode),
    .strobe     (strobe)
  );

  tcam_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uData (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .wrIdx     (wrIdx),
    .wrData    (wrData),
    .delIdx    (delIdx),
    .srchKey   (srchKey),
    .matchHit  (matchHit),
    .matchIdx  (matchIdx),
    .tableFull (tableFull),
    .delValid  (delValid),
    .delAddr   (delAddr)
  );

  // external RAM is written at the same index, same cycle
  assign ramWe   = strobe.doWrite;
  assign ramAddr = wrIdx;

endmodule

// File: tb/tcam_lookup_test.sv
module tcam_lookup_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int IDXW = 5;
  localparam logic [31:0] BASE = 32'hC0A8_1234;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 0, srchEn = 0, delIdxEn = 0, delMatchEn = 0, ternMode = 0;
  logic [IDXW-1:0] wrIdx = '0, delIdx = '0;
  logic [63:0] wrData = '0, srchKey = '0;
  logic matchHit, tableFull, ramWe, delValid;
  logic [IDXW-1:0] matchIdx, ramAddr, delAddr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tcam_lookup uut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .srchEn(srchEn), .delIdxEn(delIdxEn), .delIdx(delIdx),
    .delMatchEn(delMatchEn), .ternMode(ternMode), .srchKey(srchKey),
    .matchHit(matchHit), .matchIdx(matchIdx), .tableFull(tableFull),
    .ramWe(ramWe), .ramAddr(ramAddr), .delValid(delValid), .delAddr(delAddr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] binWord(input int i);
    return 64'h5A5A_0000_1234_0000 ^ (64'(i) * 64'h0102_0408_1020_4081);
  endfunction

  function automatic logic [63:0] prefWord(input int len);
    logic [31:0] m;
    m = ~32'h0 << (32 - len);
    return {~BASE & m, BASE & m};
  endfunction

  // all tasks start and end at a falling edge
  task automatic doWrite(input int idx, input logic [63:0] data);
    wrEn = 1; wrIdx = IDXW'(idx); wrData = data;
    #1;
    chk("R1 ramWe", 64'(ramWe), 64'd1);
    chk("R1 ramAddr", 64'(ramAddr), 64'(idx));
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic doSearch(input logic mode, input logic [63:0] key);
    srchEn = 1; ternMode = mode; srchKey = key;
    @(negedge clk);
    srchEn = 0;
  endtask

  task automatic doDelIdx(input int idx);
    delIdxEn = 1; delIdx = IDXW'(idx);
    @(negedge clk);
    delIdxEn = 0;
  endtask

  task automatic doDelMatch(input logic mode, input logic [63:0] key);
    delMatchEn = 1; ternMode = mode; srchKey = key;
    @(negedge clk);
    delMatchEn = 0;
  endtask

  task automatic expectResult(input string tag, input logic hit, input int idx);
    chk({tag, " hit"}, 64'(matchHit), 64'(hit));
    chk({tag, " idx"}, 64'(matchIdx), hit ? 64'(idx) : 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R6 R9 R5: reset state
    chk("R9 full after reset", 64'(tableFull), 64'd0);
    chk("R5 hit after reset", 64'(matchHit), 64'd0);
    chk("R7 delValid after reset", 64'(delValid), 64'd0);
    doSearch(0, binWord(0));
    expectResult("R6 empty table", 0, 0);

    // R1 R9: fill with exact words
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) chk("R9 not full yet", 64'(tableFull), 64'd0);
      doWrite(i, binWord(i));
    end
    chk("R9 full", 64'(tableFull), 64'd1);

    // R2 R4: exact search sweep
    for (int i = 0; i < DEPTH; i++) begin
      doSearch(0, binWord(i));
      expectResult("R2 exact", 1, i);
    end
    doSearch(0, binWord(40));
    expectResult("R5 exact miss", 0, 0);
    doSearch(0, binWord(3) ^ 64'h8000_0000_0000_0000);
    expectResult("R2 one bit off", 0, 0);

    // R10: search raised with a write is dropped, result holds
    wrEn = 1; wrIdx = 5'd20; wrData = binWord(5);
    srchEn = 1; ternMode = 0; srchKey = binWord(3);
    @(negedge clk);
    wrEn = 0; srchEn = 0;
    expectResult("R10 search ignored", 0, 0);

    // R4: duplicate at 5 and 20
    doSearch(0, binWord(5));
    expectResult("R4 lowest duplicate", 1, 5);
    doDelIdx(5);
    chk("R7 delValid", 64'(delValid), 64'd1);
    chk("R7 delAddr", 64'(delAddr), 64'd5);
    chk("R9 full drops", 64'(tableFull), 64'd0);
    doSearch(0, binWord(5));
    expectResult("R6 invalid skipped", 1, 20);

    // R3 R4: prefixes, entry i holds a /(32-i) prefix of BASE
    for (int i = 0; i < DEPTH; i++) doWrite(i, prefWord(32 - i));
    chk("R9 full again", 64'(tableFull), 64'd1);
    doSearch(1, {32'h0, BASE});
    expectResult("R3 exact address", 1, 0);
    for (int j = 0; j < 32; j++) begin
      int c;
      c = 31 - j;
      doSearch(1, {32'hFFFF_FFFF, BASE ^ (32'h1 << j)});
      expectResult($sformatf("R3 flip bit %0d", j), c >= 1, 32 - c);
    end

    // R2: exact mode on a ternary word in the same table
    doSearch(0, prefWord(25));
    expectResult("R2 mixed table", 1, 7);

    // R6 R8: deletions
    doDelIdx(0);
    doSearch(1, {32'h0, BASE});
    expectResult("R6 deleted entry skipped", 1, 1);
    doDelMatch(1, {32'h0, BASE});
    chk("R8 delValid", 64'(delValid), 64'd1);
    chk("R8 delAddr", 64'(delAddr), 64'd1);
    doSearch(1, {32'h0, BASE});
    expectResult("R8 next longest", 1, 2);
    doDelMatch(1, {32'h0, BASE ^ 32'h8000_0000});
    chk("R8 no hit delValid", 64'(delValid), 64'd0);
    chk("R8 no hit delAddr", 64'(delAddr), 64'd0);
    doSearch(1, {32'h0, BASE});
    expectResult("R8 nothing removed", 1, 2);

    // R1: rewrite a deleted entry revalidates it
    doWrite(0, prefWord(32));
    doSearch(1, {32'h0, BASE});
    expectResult("R1 revalidated", 1, 0);

    // R6: reset clears validity
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    chk("R9 full after reset", 64'(tableFull), 64'd0);
    doSearch(1, {32'h0, BASE});
    expectResult("R6 cleared by reset", 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule